// File: doc/BRIEF.md
# Shareable Stereo Serial Audio Transmitter

This block sends 16-bit two's-complement audio samples, most significant bit first, on a serial data line. It is built so that two mono converters can share one line as a stereo pair. A channel strap tells each instance whether it owns the left or the right half of the word clock. The instance drives the line only during its own half and releases its output enable during the other half, so exactly one driver is active at a time.

A format strap selects the frame. In I2S timing the first bit slot of a half-frame carries a zero and the MSB follows one bit period after the word-clock change. In processor (left-justified) timing the MSB goes out in the first slot. Once the 16 data bits have gone, the rest of the half-frame carries zeros and the enable stays on. The block runs on one fast system clock. It watches the bit clock for falling edges and samples the word clock on those edges. A parallel sample with a valid strobe is kept in a holding register, which is copied into the shifter when the instance's own half-frame begins.

Top module: `stx_serial_tx`

## Requirements
- R1: Each 16-bit two's-complement sample is sent most significant bit first, one bit per bit slot.
- R2: The data output and the output enable change only in the system-clock cycle after a bit-clock falling edge is seen. They hold steady while the bit clock is high.
- R3: With the channel strap high (right), the enable is on for every bit slot in which the word clock is high and off while it is low.
- R4: With the channel strap low (left), the enable is on for every bit slot in which the word clock is low and off while it is high.
- R5: With the format strap high (I2S), slot 0 of the own half-frame carries 0 and slots 1 to 16 carry sample bits 15 down to 0.
- R6: With the format strap low (processor format), slots 0 to 15 of the own half-frame carry sample bits 15 down to 0.
- R7: Every slot after the last data bit of the half-frame carries 0 while the enable stays on.
- R8: The sample that goes out is the holding-register value at the start of the own half-frame. Strobes made during a transmission do not change it. The last strobe before the next own half-frame is the one sent then.
- R9: The clear input is synchronous and active high. It turns off the enable, forces the data to 0 and empties the holding register. After a clear, the block drives nothing until it sees a word-clock change into its own phase.
- R10: Two instances with opposite channel straps never both enable their outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must run several times faster than the bit clock |
| clr | input | 1 | Synchronous active-high clear |
| bclk | input | 1 | Bit clock; a new bit goes out after each falling edge |
| wclk | input | 1 | Word clock; selects the channel half-frame |
| chan_right | input | 1 | Channel strap: 1 = right (word clock high), 0 = left |
| fmt_i2s | input | 1 | Format strap: 1 = I2S, 0 = processor left-justified |
| smp_data | input | 16 | Parallel two's-complement sample |
| smp_valid | input | 1 | Captures smp_data into the holding register |
| sd_o | output | 1 | Serial data bit (0 when not enabled) |
| sd_oe | output | 1 | Output enable for the shared line driver |

## Verification
Two instances with opposite straps share one modelled line. They are run through complete stereo frames in both formats, with a 20-slot half-frame so that the zero padding is visible. The sample stream starts with the extreme codes 0x8000, 0x7FFF, 0x0000 and 0xFFFF and with alternating patterns. A walking single one follows, which exposes any bit that is misordered or shifted by one slot. Arithmetic mixes come last. A replacement sample is strobed in the middle of each transmission, with a decoy value strobed just before it. This separates correct latching at the half-frame start from leakage of a later strobe, and shows that the last strobe wins. The half-frame right after a clear must stay undriven, which shows that the block waits for a real phase change before it starts.

// File: rtl/stx_pkg.sv
`timescale 1ns/1ps
package stx_pkg;

    localparam int unsigned SMP_W = 16;

    typedef enum logic {
        FMT_LJ  = 1'b0,
        FMT_I2S = 1'b1
    } fmt_e;

    // per-system-clock slot control produced by the clock sense stage
    typedef struct packed {
        logic tick;     // bit-clock falling edge seen this cycle
        logic start;    // own half-frame begins on this tick
        logic stop;     // other channel's half-frame on this tick
        logic own_now;  // word clock currently in own phase
        logic own_q;    // phase recorded at the last tick
    } slot_ctl_t;

    typedef struct packed {
        logic bit_o;
        logic en;
    } line_t;

    function automatic fmt_e fmt_of(input logic strap);
        return strap ? FMT_I2S : FMT_LJ;
    endfunction

endpackage

// File: rtl/stx_clk_sense.sv
`timescale 1ns/1ps
module stx_clk_sense
    import stx_pkg::*;
(
    input  logic      clk,
    input  logic      clr,
    input  logic      bclk,
    input  logic      wclk,
    input  logic      chan_right,
    output slot_ctl_t ctl
);

    logic bclk_q;
    logic armed_q;
    logic own_q;
    logic tick;
    logic own_now;

    assign tick    = bclk_q & ~bclk;
    assign own_now = (wclk == chan_right);

    always_ff @(posedge clk) begin
        if (clr) begin
            bclk_q  <= 1'b0;
            armed_q <= 1'b0;
            own_q   <= 1'b0;
        end else begin
            bclk_q <= bclk;
            if (tick) begin
                armed_q <= 1'b1;
                own_q   <= own_now;
            end
        end
    end

    always_comb begin
        ctl.tick    = tick;
        ctl.own_now = own_now;
        ctl.own_q   = own_q;
        ctl.start   = tick & armed_q & own_now & ~own_q;
        ctl.stop    = tick & ~own_now;
    end

    // R9: leaving clear, no phase has been observed yet
    a_r9_unarmed: assert property (@(posedge clk) disable iff (clr)
        $fell(clr) |-> (!armed_q && !own_q));

    // R2: the recorded phase only moves on a bit-clock fall
    a_r2_phase_on_tick: assert property (@(posedge clk) disable iff (clr)
        !tick |=> $stable(own_q));

endmodule

// File: rtl/stx_sample_hold.sv
`timescale 1ns/1ps
module stx_sample_hold #(
    parameter int unsigned W = stx_pkg::SMP_W
) (
    input  logic         clk,
    input  logic         clr,
    input  logic [W-1:0] smp_data,
    input  logic         smp_valid,
    output logic [W-1:0] held
);

    logic [W-1:0] held_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            held_q <= '0;
        end else if (smp_valid) begin
            held_q <= smp_data;
        end
    end

    assign held = held_q;

    // R8: the holding value moves only on a strobe
    a_r8_hold_steady: assert property (@(posedge clk) disable iff (clr)
        !smp_valid |=> $stable(held_q));

    // R9: clear empties the holding register
    a_r9_hold_clear: assert property (@(posedge clk) disable iff (clr)
        $fell(clr) |-> (held_q == '0));

endmodule

// File: rtl/stx_shifter.sv
`timescale 1ns/1ps
module stx_shifter
    import stx_pkg::*;
#(
    parameter int unsigned W = stx_pkg::SMP_W
) (
    input  logic         clk,
    input  logic         clr,
    input  fmt_e         fmt,
    input  slot_ctl_t    ctl,
    input  logic [W-1:0] word_i,
    output line_t        line
);

    localparam int unsigned MSB = W - 1;

    logic [W-1:0] sh_q;
    logic         bit_q;
    logic         en_q;

    // bit shown in slot 0 of an own half-frame
    function automatic logic lead_bit(input fmt_e f, input logic [W-1:0] w);
        return (f == FMT_I2S) ? 1'b0 : w[MSB];
    endfunction

    // contents left in the shifter after slot 0
    function automatic logic [W-1:0] preload(input fmt_e f, input logic [W-1:0] w);
        return (f == FMT_I2S) ? w : {w[MSB-1:0], 1'b0};
    endfunction

    always_ff @(posedge clk) begin
        if (clr) begin
            sh_q  <= '0;
            bit_q <= 1'b0;
            en_q  <= 1'b0;
        end else if (ctl.start) begin
            en_q  <= 1'b1;
            bit_q <= lead_bit(fmt, word_i);
            sh_q  <= preload(fmt, word_i);
        end else if (ctl.stop) begin
            en_q  <= 1'b0;
            bit_q <= 1'b0;
        end else if (ctl.tick && en_q) begin
            bit_q <= sh_q[MSB];
            sh_q  <= {sh_q[MSB-1:0], 1'b0};
        end
    end

    assign line.bit_o = bit_q;
    assign line.en    = en_q;

    // R2: enable and data only move after a bit-clock fall
    a_r2_en_steady: assert property (@(posedge clk) disable iff (clr)
        !ctl.tick |=> $stable(en_q));
    a_r2_bit_steady: assert property (@(posedge clk) disable iff (clr)
        !ctl.tick |=> $stable(bit_q));

    // R3 / R4: enabled only while the last sampled phase is our own
    a_r3_r4_own_phase: assert property (@(posedge clk) disable iff (clr)
        en_q |-> ctl.own_q);

    // R5: I2S leads with a zero slot
    a_r5_i2s_lead: assert property (@(posedge clk) disable iff (clr)
        (ctl.start && fmt == FMT_I2S) |=> (en_q && !bit_q));

    // R6: processor format leads with the MSB of the held sample
    a_r6_lj_lead: assert property (@(posedge clk) disable iff (clr)
        (ctl.start && fmt == FMT_LJ) |=> (en_q && bit_q == $past(word_i[MSB])));

    // R9: clear leaves the line released and low
    a_r9_line_clear: assert property (@(posedge clk) disable iff (clr)
        $fell(clr) |-> (!en_q && !bit_q));

endmodule

// File: rtl/stx_serial_tx.sv
`timescale 1ns/1ps
module stx_serial_tx
    import stx_pkg::*;
#(
    parameter int unsigned W = stx_pkg::SMP_W
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         bclk,
    input  logic         wclk,
    input  logic         chan_right,
    input  logic         fmt_i2s,
    input  logic [W-1:0] smp_data,
    input  logic         smp_valid,
    output logic         sd_o,
    output logic         sd_oe
);

    slot_ctl_t    ctl;
    logic [W-1:0] held;
    line_t        line;
    fmt_e         fmt;

    assign fmt = fmt_of(fmt_i2s);

    stx_clk_sense u_sense (
        .clk        (clk),
        .clr        (clr),
        .bclk       (bclk),
        .wclk       (wclk),
        .chan_right (chan_right),
        .ctl        (ctl)
    );

    stx_sample_hold #(.W(W)) u_hold (
        .clk       (clk),
        .clr       (clr),
        .smp_data  (smp_data),
        .smp_valid (smp_valid),
        .held      (held)
    );

    stx_shifter #(.W(W)) u_shift (
        .clk    (clk),
        .clr    (clr),
        .fmt    (fmt),
        .ctl    (ctl),
        .word_i (held),
        .line   (line)
    );

    assign sd_o  = line.bit_o;
    assign sd_oe = line.en;

    // R9: released data is always low
    a_r9_low_when_off: assert property (@(posedge clk) disable iff (clr)
        !sd_oe |-> !sd_o);

endmodule

// File: tb/sim_stx_serial_tx.sv
`timescale 1ns/1ps
module sim_stx_serial_tx;

    localparam int HB = 4;    // system clocks per bit-clock half
    localparam int SL = 20;   // bit slots per half-frame
    localparam int NF = 30;   // stereo frames per format

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic clr = 1'b1, bclk = 1'b1, wclk = 1'b1, fmt = 1'b0;
    logic [15:0] d0 = '0, d1 = '0;
    logic v0 = 1'b0, v1 = 1'b0;
    logic so0, oe0, so1, oe1;

    int checks = 0, errors = 0, both_on = 0, r2_bad = 0, idx = 0;
    logic [SL-1:0] cap_d, cap_own, cap_oth;
    logic [15:0] held_l, held_r;

    stx_serial_tx u0 (.clk(clk), .clr(clr), .bclk(bclk), .wclk(wclk), .chan_right(1'b0),
        .fmt_i2s(fmt), .smp_data(d0), .smp_valid(v0), .sd_o(so0), .sd_oe(oe0));
    stx_serial_tx u1 (.clk(clk), .clr(clr), .bclk(bclk), .wclk(wclk), .chan_right(1'b1),
        .fmt_i2s(fmt), .smp_data(d1), .smp_valid(v1), .sd_o(so1), .sd_oe(oe1));

    // R10: shared line must never have two drivers
    always @(negedge clk) if (!clr && oe0 && oe1) both_on++;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] smp_of(input int i);
        case (i)
            0: return 16'h8000;
            1: return 16'h7FFF;
            2: return 16'h0000;
            3: return 16'hFFFF;
            4: return 16'hA5A5;
            5: return 16'h5A5A;
            default: if (i < 22) return 16'h0001 << (i - 6);
                     else return 16'(i * 16'h3B5D) ^ 16'h1234;
        endcase
    endfunction

    // expected slot value from the format rules (R1 R5 R6 R7)
    function automatic logic [SL-1:0] exp_vec(input logic f, input logic [15:0] s);
        logic [SL-1:0] v = '0;
        for (int k = 0; k < SL; k++) begin
            if (f) v[k] = (k >= 1 && k <= 16) ? s[16-k] : 1'b0;
            else   v[k] = (k < 16) ? s[15-k] : 1'b0;
        end
        return v;
    endfunction

    task automatic strobe(input bit right, input logic [15:0] val);
        if (right) begin d1 = val; v1 = 1'b1; end else begin d0 = val; v0 = 1'b1; end
        @(negedge clk);
        v0 = 1'b0; v1 = 1'b0;
    endtask

    task automatic do_slot(input logic wc, input int k);
        logic m0, e0, m1, e1;
        bclk = 1'b0; wclk = wc;
        repeat (HB) @(negedge clk);
        bclk = 1'b1;
        cap_d[k]   = wc ? so1 : so0;
        cap_own[k] = wc ? oe1 : oe0;
        cap_oth[k] = wc ? oe0 : oe1;
        m0 = so0; e0 = oe0; m1 = so1; e1 = oe1;
        repeat (HB) @(negedge clk);
        if (so0 != m0 || oe0 != e0 || so1 != m1 || oe1 != e1) r2_bad++;
    endtask

    task automatic run_half(input logic wc, input bit chk_on, input logic [15:0] exp_word);
        logic [15:0] nxt;
        r2_bad = 0;
        for (int k = 0; k < SL; k++) begin
            if (k == 10 && chk_on) begin
                nxt = smp_of(idx); idx++;
                strobe(wc, ~nxt);   // decoy, overwritten below (R8)
                strobe(wc, nxt);
                if (wc) held_r = nxt; else held_l = nxt;
            end
            do_slot(wc, k);
        end
        if (chk_on) begin
            chk(cap_d == exp_vec(fmt, exp_word), fmt ? "R1 R5 R7 R8" : "R1 R6 R7 R8",
                32'(cap_d), 32'(exp_vec(fmt, exp_word)));
            chk(cap_own == '1 && cap_oth == '0, wc ? "R3 enable" : "R4 enable",
                {cap_own, 12'h0}, {{SL{1'b1}}, 12'h0});
            chk(r2_bad == 0, "R2 stable while bit clock high", r2_bad, 0);
        end else begin
            chk(cap_own == '0 && cap_oth == '0, "R9 idle after clear",
                {cap_own, cap_oth}, 0);
        end
    endtask

    task automatic run_format(input logic f);
        fmt = f;
        clr = 1'b1; bclk = 1'b1;
        repeat (3) @(negedge clk);
        clr = 1'b0;
        @(negedge clk);
        chk(!oe0 && !oe1 && !so0 && !so1, "R9 reset state", {oe0, so0, oe1, so1}, 0);
        idx = 0;
        held_l = smp_of(idx); idx++; strobe(1'b0, held_l);
        held_r = smp_of(idx); idx++; strobe(1'b1, held_r);
        run_half(1'b1, 1'b0, 16'h0);
        for (int fr = 0; fr < NF; fr++) begin
            run_half(1'b0, 1'b1, held_l);
            run_half(1'b1, 1'b1, held_r);
        end
    endtask

    initial begin
        repeat (2) @(negedge clk);
        run_format(1'b0);
        run_format(1'b1);
        chk(both_on == 0, "R10 single driver", both_on, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule